// File: doc/BRIEF.md
# Boundary Scan Pad Register Chain

This block sits between a chip's core logic and its I/O pads and gives a test controller serial access to every pad. Each pad owns two chain positions: an enable cell that decides whether the pad drives or floats in test mode, followed by a value cell that holds the level to drive and records the level actually seen on the pad. All positions form one shift path from a serial input to a serial output. The state machine and instruction decoding that produce the strobes live elsewhere.

In normal operation the core's drive value and enable reach the pads unchanged. The chain can still record pad levels and shift them out for observation. When the external-test strobe is high, the pads take their drive value and enable from a hold stage in each cell instead of from the core. Values shifted into the chain reach the pads only on an update strobe, so the pads stay steady while a new pattern is shifted in. A board test drives one pad to 1 and then to 0, records all pads, and shifts the recorded levels out to find opens and shorts.

Top module: `bsr_chain`

## Requirements
- R1: Synchronous reset clears every shift and hold stage. After reset with external test selected, all pad enables are 0 (high impedance) and the serial output is 0.
- R2: With external test deselected, pad_out_o equals core_out_i and pad_oe_o equals core_oe_i. core_in_o always equals pad_in_i, in both modes.
- R3: The chain has 2*NUM_PADS positions. Position 2i is the enable cell of pad i and position 2i+1 is its value cell. Position 0 takes scan_in_i. On a shift strobe every position takes the value of the position below it. scan_out_o shows the shift stage of the last position.
- R4: On a capture strobe, in either mode, the enable cell of pad i loads core_oe_i[i] and the value cell of pad i loads pad_in_i[i]. All positions load in the same cycle.
- R5: When capture and shift are both asserted in one cycle, capture wins.
- R6: Shifting without an update strobe leaves pad_out_o and pad_oe_o unchanged in test mode.
- R7: On an update strobe each hold stage copies its shift stage. In test mode pad_oe_o[i] is the hold value of the enable cell and pad_out_o[i] is the hold value of the value cell. An enable hold of 0 floats the pad, and the core's drive value and enable are ignored.
- R8: An update strobe in the same cycle as a shift strobe copies the values from before that shift.
- R9: Deselecting external test hands the pads back to the core in the same cycle. The hold stages keep their values, and the pads take those values again when test mode returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_i | input | 1 | Synchronous active-high reset of the chain |
| extest_i | input | 1 | External test selected; pads are driven from the hold stages |
| capture_i | input | 1 | Parallel load of all shift stages |
| shift_i | input | 1 | Shift the chain by one position |
| update_i | input | 1 | Copy shift stages into hold stages |
| scan_in_i | input | 1 | Serial data into position 0 |
| core_out_i | input | NUM_PADS | Core drive value per pad |
| core_oe_i | input | NUM_PADS | Core drive enable per pad |
| pad_in_i | input | NUM_PADS | Level sensed on each pad |
| pad_out_o | output | NUM_PADS | Drive value to each pad |
| pad_oe_o | output | NUM_PADS | Drive enable to each pad, 0 = high impedance |
| core_in_o | output | NUM_PADS | Pad level handed to the core |
| scan_out_o | output | 1 | Serial data from the last position |

## Verification
The bench builds the block with NUM_PADS = 4. This gives an 8-position chain, so every full pattern can be written and read back in eight shift cycles, and each cell's position can be checked bit by bit. A board model around the pads feeds each driven level back to its own input and can join pad 0 to pad 1 as a shared trace. With that model, the drive-1 and drive-0 interconnect test and the high-impedance release can be seen through the recorded pad levels.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    typedef enum logic {
        CELL_ENABLE = 1'b0,
        CELL_VALUE  = 1'b1
    } cell_role_e;

    typedef struct packed {
        logic shf;
        logic hld;
    } cell_state_t;

    typedef struct packed {
        logic drive;
        logic enable;
    } pad_drive_t;

    function automatic int unsigned chain_len(input int unsigned pads);
        return 2 * pads;
    endfunction

    function automatic int unsigned enable_pos(input int unsigned pad);
        return 2 * pad;
    endfunction

    function automatic int unsigned value_pos(input int unsigned pad);
        return 2 * pad + 1;
    endfunction

    function automatic pad_drive_t pick_drive(input logic test_mode,
                                              input pad_drive_t core_side,
                                              input pad_drive_t held_side);
        return test_mode ? held_side : core_side;
    endfunction

endpackage

// File: rtl/bsr_cell.sv
module bsr_cell
    import bsr_pkg::*;
#(
    parameter cell_role_e ROLE = CELL_VALUE
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic capture_i,
    input  logic shift_i,
    input  logic update_i,
    input  logic enable_obs_i,
    input  logic level_obs_i,
    input  logic ser_i,
    output logic ser_o,
    output logic hold_o
);

    cell_state_t st_q;
    cell_state_t st_d;
    logic        obs;

    generate
        if (ROLE == CELL_ENABLE) begin : g_enable_obs
            assign obs = enable_obs_i;
        end else begin : g_level_obs
            assign obs = level_obs_i;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (capture_i) begin
            st_d.shf = obs;
        end else if (shift_i) begin
            st_d.shf = ser_i;
        end
        if (update_i) begin
            st_d.hld = st_q.shf;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_o  = st_q.shf;
    assign hold_o = st_q.hld;

endmodule

// File: rtl/bsr_pad_mux.sv
module bsr_pad_mux
    import bsr_pkg::*;
(
    input  logic test_mode_i,
    input  logic core_out_i,
    input  logic core_oe_i,
    input  logic hold_value_i,
    input  logic hold_enable_i,
    output logic pad_out_o,
    output logic pad_oe_o
);

    pad_drive_t core_side;
    pad_drive_t held_side;
    pad_drive_t chosen;

    always_comb begin
        core_side.drive  = core_out_i;
        core_side.enable = core_oe_i;
        held_side.drive  = hold_value_i;
        held_side.enable = hold_enable_i;
        chosen           = pick_drive(test_mode_i, core_side, held_side);
    end

    assign pad_out_o = chosen.drive;
    assign pad_oe_o  = chosen.enable;

endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
    import bsr_pkg::*;
#(
    parameter int unsigned NUM_PADS = 8
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                extest_i,
    input  logic                capture_i,
    input  logic                shift_i,
    input  logic                update_i,
    input  logic                scan_in_i,
    input  logic [NUM_PADS-1:0] core_out_i,
    input  logic [NUM_PADS-1:0] core_oe_i,
    input  logic [NUM_PADS-1:0] pad_in_i,
    output logic [NUM_PADS-1:0] pad_out_o,
    output logic [NUM_PADS-1:0] pad_oe_o,
    output logic [NUM_PADS-1:0] core_in_o,
    output logic                scan_out_o
);

    localparam int unsigned CHAIN_LEN = chain_len(NUM_PADS);

    logic [CHAIN_LEN:0]   link;
    logic [CHAIN_LEN-1:0] held;

    assign link[0] = scan_in_i;

    generate
        for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
            localparam int unsigned EN_POS = enable_pos(p);
            localparam int unsigned VL_POS = value_pos(p);

            bsr_cell #(.ROLE(CELL_ENABLE)) u_en_cell (
                .clk_i        (clk_i),
                .rst_i        (rst_i),
                .capture_i    (capture_i),
                .shift_i      (shift_i),
                .update_i     (update_i),
                .enable_obs_i (core_oe_i[p]),
                .level_obs_i  (pad_in_i[p]),
                .ser_i        (link[EN_POS]),
                .ser_o        (link[EN_POS+1]),
                .hold_o       (held[EN_POS])
            );

            bsr_cell #(.ROLE(CELL_VALUE)) u_val_cell (
                .clk_i        (clk_i),
                .rst_i        (rst_i),
                .capture_i    (capture_i),
                .shift_i      (shift_i),
                .update_i     (update_i),
                .enable_obs_i (core_oe_i[p]),
                .level_obs_i  (pad_in_i[p]),
                .ser_i        (link[VL_POS]),
                .ser_o        (link[VL_POS+1]),
                .hold_o       (held[VL_POS])
            );

            bsr_pad_mux u_mux (
                .test_mode_i   (extest_i),
                .core_out_i    (core_out_i[p]),
                .core_oe_i     (core_oe_i[p]),
                .hold_value_i  (held[VL_POS]),
                .hold_enable_i (held[EN_POS]),
                .pad_out_o     (pad_out_o[p]),
                .pad_oe_o      (pad_oe_o[p])
            );
        end
    endgenerate

    assign core_in_o  = pad_in_i;
    assign scan_out_o = link[CHAIN_LEN];

endmodule

// File: rtl/bsr_chain_chk.sv
module bsr_chain_chk #(
    parameter int unsigned NUM_PADS = 8
) (
    input logic                clk_i,
    input logic                rst_i,
    input logic                extest_i,
    input logic                capture_i,
    input logic                update_i,
    input logic [NUM_PADS-1:0] core_out_i,
    input logic [NUM_PADS-1:0] core_oe_i,
    input logic [NUM_PADS-1:0] pad_in_i,
    input logic [NUM_PADS-1:0] pad_out_o,
    input logic [NUM_PADS-1:0] pad_oe_o,
    input logic                scan_out_o
);

    logic seen_q = 1'b0;

    always_ff @(posedge clk_i) begin
        seen_q <= 1'b1;
    end

    // R1
    reset_release_chk: assert property (@(posedge clk_i)
        (seen_q && $past(rst_i) && !rst_i && extest_i)
        |-> (pad_oe_o == '0 && scan_out_o == 1'b0));

    // R6
    hold_steady_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (seen_q && extest_i && $past(extest_i) && !$past(update_i) && !$past(rst_i))
        |-> ($stable(pad_out_o) && $stable(pad_oe_o)));

    // R4
    capture_last_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (seen_q && $past(capture_i) && !$past(rst_i))
        |-> (scan_out_o == $past(pad_in_i[NUM_PADS-1])));

    // R9
    core_owns_pads_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !extest_i |-> (pad_out_o == core_out_i && pad_oe_o == core_oe_i));

endmodule

bind bsr_chain bsr_chain_chk #(.NUM_PADS(NUM_PADS)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .extest_i   (extest_i),
    .capture_i  (capture_i),
    .update_i   (update_i),
    .core_out_i (core_out_i),
    .core_oe_i  (core_oe_i),
    .pad_in_i   (pad_in_i),
    .pad_out_o  (pad_out_o),
    .pad_oe_o   (pad_oe_o),
    .scan_out_o (scan_out_o)
);

// File: tb/sim_bsr_chain.sv
`timescale 1ns/1ps
module sim_bsr_chain;

    localparam int N = 4;
    localparam int L = 2 * N;

    // entry: core_out, core_oe, ext level, exp pad_out, exp pad_oe, exp core_in
    localparam logic [6*N-1:0] VEC [4] = '{
        {4'b0000, 4'b0000, 4'b1010, 4'b0000, 4'b0000, 4'b1010},
        {4'b1111, 4'b1111, 4'b0000, 4'b1111, 4'b1111, 4'b1111},
        {4'b1010, 4'b1100, 4'b0101, 4'b1010, 4'b1100, 4'b1001},
        {4'b0110, 4'b0011, 4'b1001, 4'b0110, 4'b0011, 4'b1010}
    };

    logic clk = 1'b0;
    logic rst, extest, capture, shift, update, scan_in;
    logic [N-1:0] core_out, core_oe, ext_lvl, pad_in_w;
    logic [N-1:0] pad_out, pad_oe, core_in;
    logic scan_out;
    logic trace01;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    // board model: a driven pad reads back its own level; optional trace joins pad 0 to pad 1
    always_comb begin
        for (int i = 0; i < N; i++) begin
            pad_in_w[i] = pad_oe[i] ? pad_out[i] : ext_lvl[i];
        end
        if (trace01 && pad_oe[0]) pad_in_w[1] = pad_out[0];
    end

    bsr_chain #(.NUM_PADS(N)) u0 (
        .clk_i(clk), .rst_i(rst), .extest_i(extest), .capture_i(capture),
        .shift_i(shift), .update_i(update), .scan_in_i(scan_in),
        .core_out_i(core_out), .core_oe_i(core_oe), .pad_in_i(pad_in_w),
        .pad_out_o(pad_out), .pad_oe_o(pad_oe), .core_in_o(core_in),
        .scan_out_o(scan_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [L-1:0] pack(input logic [N-1:0] en, input logic [N-1:0] val);
        logic [L-1:0] r;
        for (int i = 0; i < N; i++) begin
            r[2*i]   = en[i];
            r[2*i+1] = val[i];
        end
        return r;
    endfunction

    task automatic shift_chain(input logic [L-1:0] din, output logic [L-1:0] dout);
        for (int k = L - 1; k >= 0; k--) begin
            shift   = 1'b1;
            scan_in = din[k];
            dout[k] = scan_out;
            cyc();
        end
        shift = 1'b0;
    endtask

    task automatic pulse_update();
        update = 1'b1;
        cyc();
        update = 1'b0;
    endtask

    task automatic pulse_capture(input logic with_shift);
        capture = 1'b1;
        shift   = with_shift;
        cyc();
        capture = 1'b0;
        shift   = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [L-1:0] rd;
        logic [L-1:0] pat_c;
        logic [N-1:0] seen_lvl;
        rst = 1'b1; extest = 1'b0; capture = 1'b0; shift = 1'b0; update = 1'b0;
        scan_in = 1'b0; core_out = '0; core_oe = '0; ext_lvl = '0; trace01 = 1'b0;
        repeat (3) cyc();
        rst = 1'b0;
        extest = 1'b1;
        #1;
        // R1 reset state
        check("R1 pad_oe after reset", pad_oe, 0);
        check("R1 scan_out after reset", scan_out, 0);
        shift_chain('0, rd);
        check("R1 chain cleared", rd, 0);
        check("R1 pads float", pad_oe, 0);

        // R2 pass-through table
        extest = 1'b0;
        for (int v = 0; v < 4; v++) begin
            {core_out, core_oe, ext_lvl} = VEC[v][6*N-1:3*N];
            #1;
            check("R2 pad_out", pad_out, VEC[v][3*N-1:2*N]);
            check("R2 pad_oe", pad_oe, VEC[v][2*N-1:N]);
            check("R2 core_in", core_in, VEC[v][N-1:0]);
            cyc();
        end

        // R3 chain length and order
        shift_chain(8'b1011_0010, rd);
        check("R3 first out is last position", scan_out, 1);
        shift_chain('0, rd);
        check("R3 pattern returns intact", rd, 8'hB2);

        // R7 test mode takes held values, core ignored
        extest = 1'b1; core_out = 4'b1111; core_oe = 4'b1111; ext_lvl = '0;
        shift_chain(pack(4'b0101, 4'b0011), rd);
        pulse_update();
        check("R7 pad_oe from enable cells", pad_oe, 4'b0101);
        check("R7 pad_out from value cells", pad_out, 4'b0011);

        // R6 shifting without update keeps pads
        shift_chain(pack(4'b1010, 4'b1100), rd);
        check("R6 pad_oe steady while shifting", pad_oe, 4'b0101);
        check("R6 pad_out steady while shifting", pad_out, 4'b0011);
        pulse_update();
        check("R7 new pad_oe after update", pad_oe, 4'b1010);
        check("R7 new pad_out after update", pad_out, 4'b1100);

        // R8 update with shift copies pre-shift values
        pat_c = pack(4'b0110, 4'b1001);
        shift_chain(pat_c, rd);
        shift = 1'b1; update = 1'b1; scan_in = 1'b1;
        cyc();
        shift = 1'b0; update = 1'b0;
        check("R8 pad_oe pre-shift copy", pad_oe, 4'b0110);
        check("R8 pad_out pre-shift copy", pad_out, 4'b1001);

        // R9 hand back and return
        extest = 1'b0; core_out = 4'b0101; core_oe = 4'b0011;
        #1;
        check("R9 core drives pad_out", pad_out, 4'b0101);
        check("R9 core drives pad_oe", pad_oe, 4'b0011);
        extest = 1'b1;
        #1;
        check("R9 held pad_oe returns", pad_oe, 4'b0110);
        check("R9 held pad_out returns", pad_out, 4'b1001);

        // R5 capture beats shift
        core_oe = 4'b1010; ext_lvl = 4'b0001;
        #1;
        seen_lvl = pad_in_w;
        pulse_capture(1'b1);
        shift_chain('0, rd);
        check("R5 capture wins over shift", rd, pack(4'b1010, seen_lvl));

        // R4 interconnect: pad 0 drives 1 then 0, joined to pad 1
        trace01 = 1'b1; core_oe = '0; ext_lvl = 4'b0000;
        shift_chain(pack(4'b0001, 4'b0001), rd);
        pulse_update();
        pulse_capture(1'b0);
        shift_chain(pack(4'b0001, 4'b0000), rd);
        check("R4 drive 1 seen on joined pad", rd, pack(4'b0000, 4'b0011));
        pulse_update();
        ext_lvl = 4'b0010;
        pulse_capture(1'b0);
        shift_chain('0, rd);
        check("R4 drive 0 seen on joined pad", rd, pack(4'b0000, 4'b0000));

        // R7 enable 0 floats the pad, joined pad sees external level
        shift_chain(pack(4'b0000, 4'b0001), rd);
        pulse_update();
        check("R7 zero enable floats", pad_oe, 4'b0000);
        pulse_capture(1'b0);
        shift_chain('0, rd);
        check("R7 floated pad not driven", rd, pack(4'b0000, 4'b0010));

        // R4 capture in normal mode
        trace01 = 1'b0; extest = 1'b0;
        core_oe = 4'b0011; core_out = 4'b0001; ext_lvl = 4'b1100;
        pulse_capture(1'b0);
        shift_chain('0, rd);
        check("R4 normal-mode observe", rd, pack(4'b0011, 4'b1101));

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule